// File: doc/BRIEF.md
# Round-Robin SPI ADC Channel Scanner

This block reads an eight-input SPI analog-to-digital converter with no processor in the loop. A built-in pacing timer starts one sweep of eight conversion frames per sample period. Each frame is a 16-bit full-duplex SPI transfer in mode 3. The outgoing command word selects the channel for the following conversion. The word that comes back holds the conversion of the channel chosen one frame earlier. The block therefore tags every received word with that earlier channel and emits it as one beat of a valid/data stream.

Whenever enable rises, the block first sends a priming frame that selects channel 0 and discards whatever comes back. After that, sweep frame k sends the address of channel k+1 (frame 7 sends channel 0 again) and returns the data for channel k. SPI has no flow control, so a frame always lasts exactly 16 serial clock periods. The end of shifting is taken from a count of serial clock edges and marked by a one-cycle pulse. A trigger that arrives while a sweep is still in progress is dropped and recorded in a sticky flag. Dropping enable lets the frame in flight complete before the block goes idle.

Top module: `adc_ring_scanner`

## Requirements
- R1: While chip select is low, the serial clock makes exactly 16 rising edges, spaced CLK_DIV system clocks apart. While chip select is high, the serial clock stays high.
- R2: The block is the SPI master in mode 3. It changes MOSI on the falling serial clock edge and samples MISO on the rising edge. Both directions transfer the most significant bit first.
- R3: The priming frame sends the command word 0x0000. Sweep frame k (k = 0..7) sends ((k+1) mod 8) in command bits 13:11, and every other command bit is zero.
- R4: Sweep frame k produces exactly one sample_valid beat, with sample_chan = k and sample_data equal to the 16 bits received during that frame. Channels appear in the order 0..7 and then repeat. The priming frame produces no beat.
- R5: While enabled, with rate_div unchanged and no overrun, sweeps start exactly rate_div+1 system clocks apart.
- R6: frame_done pulses once per frame, for one cycle. The pulse comes in the cycle of the 16th rising serial clock edge, while chip select is still low.
- R7: Between frames, chip select stays high for at least CLK_DIV system clocks.
- R8: A sweep trigger that arrives during the priming frame or a running sweep sets overrun. Overrun then stays set until the block is idle with enable low, which clears it.
- R9: When enable is cleared during a frame, that frame completes with all 16 edges and delivers its sample. No further frame starts, and the next enable begins with a priming frame.
- R10: While reset is active and after it is released, chip select and the serial clock are high and MOSI, sample_valid, frame_done and overrun are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the scanner |
| rate_div | input | RATE_W | Sweep period in clocks, minus one |
| spi_miso | input | 1 | Serial data from the converter |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial command to the converter |
| sample_valid | output | 1 | Sample beat valid |
| sample_chan | output | CH_W | Channel the sample belongs to |
| sample_data | output | FRAME_W | Received 16-bit word |
| frame_done | output | 1 | End-of-shifting pulse |
| overrun | output | 1 | Sticky dropped-trigger flag |

## Verification
The assertions take several things for granted. CLK_DIV is even and at least 2. rate_div changes only while enable is low. The converter drives MISO after a falling serial clock edge, so MISO is stable at the next rising edge. The bench obeys all three: it holds CLK_DIV at 4, loads a new random rate_div only between runs with enable low, and has its converter model update MISO half a system clock after each falling edge it detects. The bench keeps rate_div above the length of one sweep to check pacing, and drops it below that length to provoke overruns.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SHIFT,
    ENG_TAIL,
    ENG_GAP
  } eng_state_e;

  typedef enum logic [1:0] {
    SEQ_OFF,
    SEQ_PRIME,
    SEQ_WAIT,
    SEQ_SWEEP
  } seq_state_e;

endpackage

// File: rtl/scan_pacer.sv
module scan_pacer #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RATE_W-1:0] rate_div,
  output logic              tick
);

  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic              tick_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!en) begin
      cnt_d = '0;
    end else if (cnt_q >= rate_div) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tick  <= tick_d;
    end
  end

  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate_div != '0) |=> !tick);

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import adc_scan_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic               miso,
  output logic               ready,
  output logic               done,
  output logic [FRAME_W-1:0] rx_word,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi
);

  localparam int HALF = CLK_DIV / 2;
  localparam int HCW  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BCW  = $clog2(FRAME_W + 1);

  eng_state_e         st_q, st_d;
  logic [HCW-1:0]     hcnt_q, hcnt_d;
  logic [BCW-1:0]     bitc_q, bitc_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [FRAME_W-1:0] rx_q, rx_d;
  logic               sclk_q, sclk_d;
  logic               cs_n_q, cs_n_d;
  logic               mosi_q, mosi_d;
  logic               done_q, done_d;
  logic               half_end;

  assign half_end = (hcnt_q == HCW'(HALF - 1));

  always_comb begin
    st_d   = st_q;
    hcnt_d = hcnt_q;
    bitc_d = bitc_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    sclk_d = sclk_q;
    cs_n_d = cs_n_q;
    mosi_d = mosi_q;
    done_d = 1'b0;
    unique case (st_q)
      ENG_IDLE: begin
        if (start) begin
          st_d   = ENG_SHIFT;
          cs_n_d = 1'b0;
          tx_d   = tx_word;
          hcnt_d = '0;
          bitc_d = '0;
        end
      end
      ENG_SHIFT: begin
        if (half_end) begin
          hcnt_d = '0;
          if (sclk_q) begin
            sclk_d = 1'b0;
            mosi_d = tx_q[FRAME_W-1];
            tx_d   = {tx_q[FRAME_W-2:0], 1'b0};
          end else begin
            sclk_d = 1'b1;
            rx_d   = {rx_q[FRAME_W-2:0], miso};
            bitc_d = bitc_q + 1'b1;
            if (bitc_q == BCW'(FRAME_W - 1)) begin
              done_d = 1'b1;
              st_d   = ENG_TAIL;
            end
          end
        end else begin
          hcnt_d = hcnt_q + 1'b1;
        end
      end
      ENG_TAIL: begin
        if (half_end) begin
          hcnt_d = '0;
          cs_n_d = 1'b1;
          mosi_d = 1'b0;
          st_d   = ENG_GAP;
        end else begin
          hcnt_d = hcnt_q + 1'b1;
        end
      end
      ENG_GAP: begin
        if (hcnt_q == HCW'(CLK_DIV - 1)) begin
          hcnt_d = '0;
          st_d   = ENG_IDLE;
        end else begin
          hcnt_d = hcnt_q + 1'b1;
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      hcnt_q <= '0;
      bitc_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b1;
      cs_n_q <= 1'b1;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hcnt_q <= hcnt_d;
      bitc_q <= bitc_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      sclk_q <= sclk_d;
      cs_n_q <= cs_n_d;
      mosi_q <= mosi_d;
      done_q <= done_d;
    end
  end

  assign ready   = (st_q == ENG_IDLE);
  assign done    = done_q;
  assign rx_word = rx_q;
  assign sclk    = sclk_q;
  assign cs_n    = cs_n_q;
  assign mosi    = mosi_q;

  // R1
  sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> sclk_q);

  // R6
  done_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!cs_n_q && sclk_q));

  // R7
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> $past(cs_n_q, 2));

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import adc_scan_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int CH_W    = $clog2(NCH),
  parameter int FRAME_W = 16,
  parameter int CH_LSB  = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic               eng_ready,
  input  logic               eng_done,
  input  logic [FRAME_W-1:0] eng_rx,
  output logic               eng_start,
  output logic [FRAME_W-1:0] eng_cmd,
  output logic               samp_valid,
  output logic [CH_W-1:0]    samp_chan,
  output logic [FRAME_W-1:0] samp_data,
  output logic               overrun
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

  seq_state_e         st_q, st_d;
  logic [CH_W-1:0]    ch_q, ch_d, ch_next;
  logic               lau_q, lau_d;
  logic               ovr_d;
  logic               v_d;
  logic [CH_W-1:0]    tag_d;
  logic [FRAME_W-1:0] dat_d;
  logic               in_frame_state;

  assign ch_next        = (ch_q == LAST_CH) ? '0 : ch_q + 1'b1;
  assign in_frame_state = (st_q == SEQ_PRIME) || (st_q == SEQ_SWEEP);
  assign eng_start      = in_frame_state && en && eng_ready && !lau_q;

  always_comb begin
    eng_cmd = '0;
    if (st_q == SEQ_SWEEP) eng_cmd[CH_LSB +: CH_W] = ch_next;
  end

  always_comb begin
    st_d  = st_q;
    ch_d  = ch_q;
    lau_d = lau_q;
    ovr_d = overrun;
    v_d   = 1'b0;
    tag_d = samp_chan;
    dat_d = samp_data;
    if (eng_start) lau_d = 1'b1;
    if (eng_done)  lau_d = 1'b0;
    unique case (st_q)
      SEQ_OFF: begin
        ch_d  = '0;
        ovr_d = 1'b0;
        if (en) st_d = SEQ_PRIME;
      end
      SEQ_PRIME: begin
        if (eng_done)           st_d = en ? SEQ_WAIT : SEQ_OFF;
        else if (!en && !lau_q) st_d = SEQ_OFF;
      end
      SEQ_WAIT: begin
        if (!en) begin
          st_d = SEQ_OFF;
        end else if (tick) begin
          st_d = SEQ_SWEEP;
          ch_d = '0;
        end
      end
      SEQ_SWEEP: begin
        if (eng_done) begin
          v_d   = 1'b1;
          tag_d = ch_q;
          dat_d = eng_rx;
          if (!en) begin
            st_d = SEQ_OFF;
            ch_d = '0;
          end else if (ch_q == LAST_CH) begin
            st_d = SEQ_WAIT;
            ch_d = '0;
          end else begin
            ch_d = ch_next;
          end
        end else if (!en && !lau_q) begin
          st_d = SEQ_OFF;
          ch_d = '0;
        end
      end
      default: st_d = SEQ_OFF;
    endcase
    if (tick && in_frame_state) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SEQ_OFF;
      ch_q       <= '0;
      lau_q      <= 1'b0;
      overrun    <= 1'b0;
      samp_valid <= 1'b0;
      samp_chan  <= '0;
      samp_data  <= '0;
    end else begin
      st_q       <= st_d;
      ch_q       <= ch_d;
      lau_q      <= lau_d;
      overrun    <= ovr_d;
      samp_valid <= v_d;
      samp_chan  <= tag_d;
      samp_data  <= dat_d;
    end
  end

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && st_q != SEQ_OFF) |=> overrun);

  // R6
  done_matches_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> lau_q);

  // R4
  beat_from_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid |-> $past(st_q == SEQ_SWEEP));

endmodule

// File: rtl/adc_ring_scanner.sv
module adc_ring_scanner #(
  parameter int CLK_DIV = 4,
  parameter int RATE_W  = 16,
  parameter int NCH     = 8,
  parameter int CH_W    = $clog2(NCH),
  parameter int FRAME_W = 16,
  parameter int CH_LSB  = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [RATE_W-1:0]  rate_div,
  input  logic               spi_miso,
  output logic               spi_sclk,
  output logic               spi_cs_n,
  output logic               spi_mosi,
  output logic               sample_valid,
  output logic [CH_W-1:0]    sample_chan,
  output logic [FRAME_W-1:0] sample_data,
  output logic               frame_done,
  output logic               overrun
);

  logic [1:0]         rsync_q;
  logic               rst_int_n;
  logic               tick;
  logic               eng_start, eng_ready, eng_done;
  logic [FRAME_W-1:0] eng_cmd, eng_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  scan_pacer #(.RATE_W(RATE_W)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (enable),
    .rate_div (rate_div),
    .tick     (tick)
  );

  scan_sequencer #(
    .NCH(NCH), .CH_W(CH_W), .FRAME_W(FRAME_W), .CH_LSB(CH_LSB)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en         (enable),
    .tick       (tick),
    .eng_ready  (eng_ready),
    .eng_done   (eng_done),
    .eng_rx     (eng_rx),
    .eng_start  (eng_start),
    .eng_cmd    (eng_cmd),
    .samp_valid (sample_valid),
    .samp_chan  (sample_chan),
    .samp_data  (sample_data),
    .overrun    (overrun)
  );

  spi_frame_engine #(.CLK_DIV(CLK_DIV), .FRAME_W(FRAME_W)) u_eng (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (eng_start),
    .tx_word (eng_cmd),
    .miso    (spi_miso),
    .ready   (eng_ready),
    .done    (eng_done),
    .rx_word (eng_rx),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi)
  );

  assign frame_done = eng_done;

endmodule

// File: tb/tb_adc_ring_scanner.sv
module tb_adc_ring_scanner;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CLK_DIV = 4;
  localparam int RATE_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enable = 1'b0;
  logic [RATE_W-1:0] rate_div = '0;
  logic              spi_miso = 1'b0;
  logic              spi_sclk, spi_cs_n, spi_mosi;
  logic              sample_valid, frame_done, overrun;
  logic [2:0]        sample_chan;
  logic [15:0]       sample_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // converter model and monitor state
  longint     cyc = 0;
  bit         prev_cs = 1'b1, prev_sclk = 1'b1;
  logic [15:0] resp = '0, cmd = '0;
  logic [2:0]  adc_ch = '0;
  int         bitpos = 15, rise_cnt = 0, done_in_frame = 0, gap_cnt = 1000;
  longint     last_rise = 0, last_sweep = 0;
  bit         have_last = 0, check_rate = 0, primed = 0;
  int         frm_idx = 0, cs_falls = 0, samp_cnt = 0;
  logic [18:0] expq[$];

  always #2.5 clk = ~clk;

  adc_ring_scanner #(.CLK_DIV(CLK_DIV), .RATE_W(RATE_W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate_div(rate_div),
    .spi_miso(spi_miso), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .sample_valid(sample_valid), .sample_chan(sample_chan),
    .sample_data(sample_data), .frame_done(frame_done), .overrun(overrun)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_cmd(bit is_sweep, int idx);
    logic [15:0] w = '0;
    if (is_sweep) w[13:11] = 3'((idx + 1) % 8);
    return w;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_cs && !spi_cs_n) begin
        check(gap_cnt >= CLK_DIV, "R7", "cs high gap", gap_cnt, CLK_DIV);
        resp = {4'b0000, adc_ch, 9'($urandom)};
        rise_cnt = 0; bitpos = 15; cmd = '0; done_in_frame = 0;
        cs_falls++;
        if (primed && frm_idx == 0) begin
          if (have_last && check_rate)
            check(cyc - last_sweep == longint'(rate_div) + 1, "R5", "sweep spacing",
                  cyc - last_sweep, longint'(rate_div) + 1);
          last_sweep = cyc; have_last = 1;
        end
      end
      if (!spi_cs_n && prev_sclk && !spi_sclk) begin
        if (bitpos >= 0) spi_miso = resp[bitpos];
        bitpos--;
      end
      if (!prev_sclk && spi_sclk) begin
        if (spi_cs_n) check(0, "R1", "rise with cs high", 1, 0);
        if (rise_cnt > 0)
          check(cyc - last_rise == CLK_DIV, "R1", "sclk period", cyc - last_rise, CLK_DIV);
        last_rise = cyc;
        cmd = {cmd[14:0], spi_mosi};
        rise_cnt++;
        if (rise_cnt == 16) begin
          check(cmd == exp_cmd(primed, frm_idx), primed ? "R3" : "R3 prime", "command",
                cmd, exp_cmd(primed, frm_idx));
          if (primed) begin
            expq.push_back({3'(frm_idx), resp});
            frm_idx = (frm_idx + 1) % 8;
          end else begin
            primed = 1;
          end
          adc_ch = cmd[13:11];
        end
      end
      if (spi_cs_n && !spi_sclk) check(0, "R1", "sclk low while idle", 0, 1);
      if (!prev_cs && spi_cs_n) begin
        check(rise_cnt == 16, "R1", "edges per frame", rise_cnt, 16);
        check(done_in_frame == 1, "R6", "done pulses per frame", done_in_frame, 1);
        gap_cnt = 0;
      end
      if (spi_cs_n) gap_cnt++;
      if (frame_done) begin
        check(!spi_cs_n && rise_cnt == 16, "R6", "done timing", rise_cnt, 16);
        done_in_frame++;
      end
      if (sample_valid) begin
        samp_cnt++;
        if (expq.size() == 0) begin
          check(0, "R4", "unexpected sample", sample_chan, 0);
        end else begin
          logic [18:0] e;
          e = expq.pop_front();
          check(sample_chan == e[18:16], "R4", "sample channel", sample_chan, e[18:16]);
          check(sample_data == e[15:0], "R2", "sample data", sample_data, e[15:0]);
        end
      end
    end
    prev_cs = spi_cs_n;
    prev_sclk = spi_sclk;
  end

  task automatic start_run(int unsigned rd, bit rate_chk);
    @(posedge clk); #1;
    rate_div = RATE_W'(rd);
    primed = 0; frm_idx = 0; have_last = 0; check_rate = rate_chk;
    enable = 1'b1;
  endtask

  task automatic wait_samples(int n);
    int target = samp_cnt + n;
    while (samp_cnt < target) @(negedge clk);
  endtask

  task automatic stop_run();
    @(posedge clk); #1 enable = 1'b0;
    @(negedge clk);
    while (!spi_cs_n) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic disable_mid_frame();
    int f0, s0;
    @(negedge clk);
    while (!(!spi_cs_n && primed)) @(negedge clk);
    repeat (5) @(negedge clk);
    @(posedge clk); #1 enable = 1'b0;
    @(negedge clk);
    while (!spi_cs_n) @(negedge clk);
    check(expq.size() == 0, "R9", "in-flight sample delivered", expq.size(), 0);
    f0 = cs_falls; s0 = samp_cnt;
    repeat (400) @(negedge clk);
    check(cs_falls == f0, "R9", "frames after disable", cs_falls - f0, 0);
    check(samp_cnt == s0, "R9", "samples after disable", samp_cnt - s0, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(spi_cs_n && spi_sclk && !spi_mosi, "R10", "spi idle in reset",
          {spi_cs_n, spi_sclk, spi_mosi}, 3'b110);
    check(!sample_valid && !frame_done && !overrun, "R10", "flags in reset",
          {sample_valid, frame_done, overrun}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(spi_cs_n && spi_sclk && !overrun && !sample_valid, "R10", "state after reset",
          {spi_cs_n, spi_sclk, overrun, sample_valid}, 4'b1100);

    // directed nominal run
    start_run(800, 1);
    wait_samples(32);
    check(overrun == 1'b0, "R8", "no overrun at slow rate", overrun, 0);
    stop_run();
    check(expq.size() == 0, "R4", "all samples seen", expq.size(), 0);

    // random runs
    for (int r = 0; r < 3; r++) begin
      start_run(700 + ($urandom % 500), 1);
      wait_samples(16 + ($urandom % 10));
      if (r == 1) disable_mid_frame();
      else stop_run();
      check(overrun == 1'b0, "R8", "no overrun random run", overrun, 0);
      check(expq.size() == 0, "R4", "samples drained", expq.size(), 0);
    end

    // directed: disable during a frame, then re-enable with priming
    start_run(900, 1);
    wait_samples(5);
    disable_mid_frame();
    start_run(900, 1);
    wait_samples(12);
    stop_run();

    // overrun: trigger faster than one sweep
    start_run(300, 0);
    wait_samples(24);
    check(overrun == 1'b1, "R8", "overrun set", overrun, 1);
    wait_samples(8);
    check(overrun == 1'b1, "R8", "overrun sticky", overrun, 1);
    stop_run();
    check(overrun == 1'b0, "R8", "overrun cleared when idle", overrun, 0);
    check(expq.size() == 0, "R4", "samples drained after overrun", expq.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule